// File: doc/BRIEF.md
# Per-Channel Sample-Time Conversion Timer

This block sets the timing of one analog-to-digital conversion. A start pulse names a channel. The block reads that channel's 3-bit sample-time code from a packed table and asserts a sampling phase for the number of half ADC-clock cycles the code selects. It then asserts a conversion phase of a fixed 12.5 ADC-clock cycles. When the conversion phase ends, it raises a one-cycle end-of-conversion pulse.

Sample times and the fixed conversion part both fall on half-cycle boundaries. The block therefore runs on a clock at twice the ADC clock, and every phase length is a whole number of these half-cycle ticks. The total conversion time equals the sample time plus 12.5 ADC cycles. The shortest total is 14 ADC cycles, which is 1 µs at a 14 MHz ADC clock.

The block decides the sample duration when it accepts a start. After that, changes to the channel index or to the code table do not affect the conversion in progress.

Top module: `smp_conv_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `sampling`, `converting`, `busy` and `eoc` are all low.
- R2: A `start` sampled high while `busy` is low is accepted, and `sampling` is high in the next cycle. The code for channel i is read from `smp_table[3*i+2 : 3*i]`.
- R3: `sampling` stays high for exactly N half-cycle ticks. N is 3, 15, 27, 57, 83, 111, 143 and 479 for codes 0 through 7.
- R4: `converting` rises in the cycle right after the last sampling cycle. It stays high for exactly `CONV_HALF` ticks (default 25, which is 12.5 ADC cycles).
- R5: `eoc` is high for exactly one cycle, right after the last converting cycle, and `busy` is low in that cycle.
- R6: `busy` equals `sampling` OR `converting`, and `sampling` and `converting` are never high together.
- R7: A `start` while `busy` is high is ignored. The conversion in progress keeps its length, and no extra conversion follows it.
- R8: A change of `ch_idx` after acceptance does not change the length of the conversion in progress.
- R9: A change of `smp_table` after acceptance does not change the length of the conversion in progress.
- R10: With code 0 the block is busy for 28 ticks in total, which is 14 ADC cycles. With code 7 it is busy for 504 ticks.
- R11: A `start` in the same cycle as `eoc` is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the ADC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to begin a conversion |
| ch_idx | input | $clog2(NUM_CH) | Channel to convert, read when start is accepted |
| smp_table | input | 3*NUM_CH | Packed sample-time codes, 3 bits per channel |
| sampling | output | 1 | Sampling phase active |
| converting | output | 1 | Fixed conversion phase active |
| busy | output | 1 | A conversion is in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench builds the block with `NUM_CH` = 8 and the default `CONV_HALF` of 25. It gives channel i the code i, so each of the eight sample-time codes can be reached by picking a channel. This covers both the 28-tick minimum and the 504-tick maximum. With eight channels, the bench can also switch the channel index and rewrite the table entry of the channel in progress while a conversion runs, and check that the length does not change.

// File: rtl/smp_conv_timer.sv
module smp_conv_timer #(
  parameter int NUM_CH    = 18,
  parameter int CONV_HALF = 25,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int MAX_SMP  = 479,
  localparam int CNT_W    = $clog2(((MAX_SMP > CONV_HALF) ? MAX_SMP : CONV_HALF) + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CH_W-1:0]       ch_idx,
  input  logic [3*NUM_CH-1:0]   smp_table,
  output logic                  sampling,
  output logic                  converting,
  output logic                  busy,
  output logic                  eoc
);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             eoc_q;
  logic [2:0]       code;
  logic [CNT_W-1:0] smp_len;

  function automatic logic [CNT_W-1:0] half_ticks(input logic [2:0] c);
    case (c)
      3'd0:    half_ticks = CNT_W'(3);
      3'd1:    half_ticks = CNT_W'(15);
      3'd2:    half_ticks = CNT_W'(27);
      3'd3:    half_ticks = CNT_W'(57);
      3'd4:    half_ticks = CNT_W'(83);
      3'd5:    half_ticks = CNT_W'(111);
      3'd6:    half_ticks = CNT_W'(143);
      default: half_ticks = CNT_W'(MAX_SMP);
    endcase
  endfunction

  assign code    = smp_table[3*int'(ch_idx) +: 3];
  assign smp_len = half_ticks(code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      eoc_q <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      case (phase)
        ST_IDLE: if (start) begin
          phase <= ST_SAMP;
          cnt   <= smp_len - 1'b1;
        end
        ST_SAMP: if (cnt == '0) begin
          phase <= ST_CONV;
          cnt   <= CNT_W'(CONV_HALF - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_CONV: if (cnt == '0) begin
          phase <= ST_IDLE;
          eoc_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign sampling   = (phase == ST_SAMP);
  assign converting = (phase == ST_CONV);
  assign busy       = sampling | converting;
  assign eoc        = eoc_q;

endmodule

// File: rtl/smp_conv_timer_chk.sv
module smp_conv_timer_chk #(
  parameter int CONV_HALF = 25
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sampling,
  input logic converting,
  input logic busy,
  input logic eoc
);

  int unsigned conv_run;

  always_ff @(posedge clk) begin
    if (!rst_n)          conv_run <= 0;
    else if (converting) conv_run <= conv_run + 1;
    else                 conv_run <= 0;
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sampling && converting)); // R6

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (sampling || converting)); // R6

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> sampling); // R2

  AST_SAMP_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sampling) |-> ($past(start) && !$past(busy))); // R7

  AST_CONV_AFTER_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(converting) |-> $past(sampling)); // R4

  AST_EOC_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> ($past(converting) && !busy)); // R5

  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc); // R5

  AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (conv_run == CONV_HALF)); // R4

endmodule

bind smp_conv_timer smp_conv_timer_chk #(.CONV_HALF(CONV_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sampling(sampling),
  .converting(converting), .busy(busy), .eoc(eoc)
);

// File: tb/test_smp_conv_timer.sv
module test_smp_conv_timer;
  localparam int NCH  = 8;
  localparam int CW   = 3;
  localparam int CONV = 25;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] ch = '0;
  logic [3*NCH-1:0] tbl;
  logic sampling, converting, busy, eoc;

  smp_conv_timer #(.NUM_CH(NCH), .CONV_HALF(CONV)) i_smp_conv_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .ch_idx(ch), .smp_table(tbl),
    .sampling(sampling), .converting(converting), .busy(busy), .eoc(eoc));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int smp_x2 [8] = '{3, 15, 27, 57, 83, 111, 143, 479};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int m_s = 0, m_c = 0;
  bit m_eoc = 0;
  bit cmp_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = 0; m_c = 0; m_eoc = 0;
    end else begin
      m_eoc = 0;
      if (m_s > 0) begin
        m_s--;
        if (m_s == 0) m_c = CONV;
      end else if (m_c > 0) begin
        m_c--;
        if (m_c == 0) m_eoc = 1;
      end else if (start) begin
        m_s = smp_x2[tbl[int'(ch)*3 +: 3]];
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk(sampling == (m_s > 0), "R3 sampling", sampling, m_s > 0);
    chk(converting == (m_s == 0 && m_c > 0), "R4 converting", converting, m_s == 0 && m_c > 0);
    chk(eoc == m_eoc, "R5 eoc", eoc, m_eoc);
    chk(busy == (m_s > 0 || m_c > 0), "R6 busy", busy, m_s > 0 || m_c > 0);
  end

  // mode 0: plain, 1: extra start mid-flight, 2: change channel and table mid-flight
  task automatic run(input int c, input int mode, input bit now, output int busy_n);
    int guard;
    logic [2:0] saved;
    if (!now) @(negedge clk);
    start = 1; ch = CW'(c);
    @(negedge clk);
    start = 0;
    chk(sampling == 1'b1, "R2 sampling after start", sampling, 1);
    busy_n = 0; guard = 0;
    saved = tbl[c*3 +: 3];
    while (!eoc && guard < 2000) begin
      if (busy) busy_n++;
      start = (mode == 1 && busy_n == 5);
      if (mode == 2 && busy_n == 5) begin
        ch = CW'(c ^ 1);
        tbl[c*3 +: 3] = ~saved;
      end
      @(negedge clk);
      guard++;
    end
    start = 0;
    tbl[c*3 +: 3] = saved;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < NCH; i++) tbl[i*3 +: 3] = 3'(i);
    repeat (3) @(negedge clk);
    chk(!sampling && !converting && !busy && !eoc, "R1 outputs in reset",
        {sampling, converting, busy, eoc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!sampling && !converting && !busy && !eoc, "R1 outputs after reset",
        {sampling, converting, busy, eoc}, 0);
    cmp_on = 1;

    run(0, 0, 0, n);
    chk(n == 28, "R10 minimum total ticks", n, 28);
    for (int c = 1; c < NCH; c++) begin
      run(c, 0, 0, n);
      chk(n == smp_x2[c] + CONV, "R3 total ticks for code", n, smp_x2[c] + CONV);
    end
    chk(smp_x2[7] + CONV == 504, "R10 maximum total ticks", smp_x2[7] + CONV, 504);

    run(3, 1, 0, n);
    chk(n == smp_x2[3] + CONV, "R7 start while busy keeps length", n, smp_x2[3] + CONV);
    @(negedge clk);
    chk(!busy, "R7 no queued conversion", busy, 0);

    run(2, 2, 0, n);
    chk(n == smp_x2[2] + CONV, "R8 R9 mid-flight channel/table change", n, smp_x2[2] + CONV);

    run(1, 0, 0, n);
    run(4, 0, 1, n);
    chk(n == smp_x2[4] + CONV, "R11 back-to-back start on eoc", n, smp_x2[4] + CONV);

    repeat (3) @(negedge clk);
    chk(!busy && !eoc, "R1 idle at end", busy, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule